// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Checker

This block runs on the host side of an attached flash array and decides when an embedded program or erase operation inside the device has finished. A one-cycle start pulse, given while the block is idle, supplies the address that the operation targets. The block then reads that location again and again over a request/acknowledge read port. It watches one status bit, which flips on every read while the device is busy, and one error bit. When the status bit holds still across two reads in a row, the operation has ended.

A raised error bit does not end the poll at once. The device may have stopped toggling in the same read that raised the error, so the block makes one more read to confirm. It reports failure only if the status bit is still flipping on that confirming read. A read budget bounds the poll. When the block fails it can optionally send a reset command write to the target address. It ends every operation with a one-cycle done pulse and a pass flag that stays valid afterwards.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, pass_o, rd_req_o and wr_req_o are all 0.
- R2: A start_i pulse seen while idle latches addr_i. From the next cycle rd_req_o is 1 and rd_addr_o carries that address. A start_i pulse seen while busy has no effect on the address or on the result.
- R3: The first completed read after a start only records the status bit (bit TOG_BIT, default 6). It never produces a verdict.
- R4: If a read returns the same status bit as the read before it, the operation ends with pass_o = 1.
- R5: If the status bit differs from the previous read and the error bit (bit ERR_BIT, default 5) is 0, polling continues with another read.
- R6: If the status bit differs and the error bit is 1, the block makes exactly one confirming read. If that read's status bit differs from the previous read, the result is a failure; otherwise it is a pass.
- R7: If MAX_POLLS reads have completed during normal polling without a verdict, the result is a failure.
- R8: On failure, with RST_ON_FAIL = 1, the block issues one write of RST_CMD to the target address. It holds wr_req_o until wr_ack_i and never raises it on a pass.
- R9: done_o is a single-cycle pulse in the cycle after the verdict, or after the reset write is acknowledged. pass_o is valid from that cycle until the next accepted start.
- R10: A read request stays asserted with an unchanged address until rd_ack_i. A read completes in each cycle where rd_req_o and rd_ack_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | AW | Location to poll |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | 1 = operation succeeded |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |
| wr_req_o | output | 1 | Write request (reset command) |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
The hardest case to reach is the confirming read after the error bit rises, because it only starts when the status bit has flipped and the error bit is set in the same read. The bench's flash responder replays a per-test list of status bytes. A list with a toggled read carrying the error bit, followed by one more toggled or steady byte, drives both the failure-with-reset-write outcome and the late-pass outcome. A second responder setting inserts several wait cycles before each acknowledge, so the request is held and a start pulse can arrive mid-poll.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_POLL    = 3'd1,
    ST_CONFIRM = 3'd2,
    ST_RSTCMD  = 3'd3,
    ST_FINISH  = 3'd4
  } tpoll_state_e;
endpackage

// File: rtl/tpoll_tracker.sv
// Holds the status bit of the previous read and flags a change.
module tpoll_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_i,
  input  logic bit_i,
  output logic primed_o,
  output logic tog_o
);
  logic prev_q, prev_d;
  logic primed_q, primed_d;

  always_comb begin
    prev_d   = prev_q;
    primed_d = primed_q;
    if (clr_i) begin
      primed_d = 1'b0;
    end else if (smp_i) begin
      prev_d   = bit_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  assign primed_o = primed_q;
  assign tog_o    = bit_i ^ prev_q;
endmodule

// File: rtl/tpoll_limit.sv
// Counts normal poll reads and flags the last one allowed.
module tpoll_limit #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/tpoll_fsm.sv
// Sequencing of polls, confirmation read, reset write and completion.
module tpoll_fsm
  import tpoll_pkg::*;
#(
  parameter bit RST_ON_FAIL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         rd_ack_i,
  input  logic         wr_ack_i,
  input  logic         primed_i,
  input  logic         tog_i,
  input  logic         err_i,
  input  logic         last_i,
  output tpoll_state_e state_o,
  output logic         accept_o,
  output logic         smp_o,
  output logic         poll_rd_o,
  output logic         pass_o
);
  localparam tpoll_state_e FAIL_ST = RST_ON_FAIL ? ST_RSTCMD : ST_FINISH;

  tpoll_state_e st_q, st_d;
  logic pass_q, pass_d;

  assign accept_o  = (st_q == ST_IDLE) && start_i;
  assign poll_rd_o = (st_q == ST_POLL) && rd_ack_i;
  assign smp_o     = rd_ack_i && ((st_q == ST_POLL) || (st_q == ST_CONFIRM));

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_POLL;
          pass_d = 1'b0;
        end
      end
      ST_POLL: begin
        if (rd_ack_i && primed_i) begin
          if (!tog_i) begin
            st_d   = ST_FINISH;
            pass_d = 1'b1;
          end else if (err_i) begin
            st_d = ST_CONFIRM;
          end else if (last_i) begin
            st_d = FAIL_ST;
          end
        end
      end
      ST_CONFIRM: begin
        if (rd_ack_i) begin
          if (tog_i) begin
            st_d = FAIL_ST;
          end else begin
            st_d   = ST_FINISH;
            pass_d = 1'b1;
          end
        end
      end
      ST_RSTCMD: begin
        if (wr_ack_i) st_d = ST_FINISH;
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
    end
  end

  assign state_o = st_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter int          TOG_BIT     = 6,
  parameter int          ERR_BIT     = 5,
  parameter int          MAX_POLLS   = 1024,
  parameter bit          RST_ON_FAIL = 1'b1,
  parameter logic [7:0]  RST_CMD     = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i
);
  tpoll_state_e  state;
  logic          accept, smp, poll_rd;
  logic          primed, tog, last;
  logic [AW-1:0] tgt_q, tgt_d;

  always_comb begin
    tgt_d = tgt_q;
    if (accept) tgt_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= '0;
    else        tgt_q <= tgt_d;
  end

  tpoll_fsm #(.RST_ON_FAIL(RST_ON_FAIL)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rd_ack_i (rd_ack_i),
    .wr_ack_i (wr_ack_i),
    .primed_i (primed),
    .tog_i    (tog),
    .err_i    (rd_data_i[ERR_BIT]),
    .last_i   (last),
    .state_o  (state),
    .accept_o (accept),
    .smp_o    (smp),
    .poll_rd_o(poll_rd),
    .pass_o   (pass_o)
  );

  tpoll_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .smp_i   (smp),
    .bit_i   (rd_data_i[TOG_BIT]),
    .primed_o(primed),
    .tog_o   (tog)
  );

  tpoll_limit #(.MAX_POLLS(MAX_POLLS)) u_lim (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept),
    .inc_i (poll_rd),
    .last_o(last)
  );

  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_FINISH);
  assign rd_req_o  = (state == ST_POLL) || (state == ST_CONFIRM);
  assign rd_addr_o = tgt_q;

  generate
    if (RST_ON_FAIL) begin : g_rstwr
      assign wr_req_o  = (state == ST_RSTCMD);
      assign wr_addr_o = tgt_q;
      assign wr_data_o = DW'(RST_CMD);
    end else begin : g_nowr
      assign wr_req_o  = 1'b0;
      assign wr_addr_o = '0;
      assign wr_data_o = '0;
    end
  endgenerate
endmodule

// File: rtl/tpoll_chk.sv
module tpoll_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          wr_req_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_o && !wr_req_o && !done_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R8
  wr_fail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (!pass_o && !rd_req_o));

  // R2
  addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(rd_addr_o));

  // R9
  pass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(pass_o));
endmodule

bind toggle_poll_ctrl tpoll_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_ack_i (rd_ack_i),
  .wr_req_o (wr_req_o)
);

// File: tb/tb_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module tb_toggle_poll_ctrl;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MAXP = 8;
  localparam logic [7:0] CMD = 8'hF0;

  logic clk, rst_n, start_i;
  logic [AW-1:0] addr_i;
  logic busy_o, done_o, pass_o, rd_req_o, rd_ack_i, wr_req_o, wr_ack_i;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [DW-1:0] rd_data_i, wr_data_o;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP), .RST_ON_FAIL(1'b1),
                     .RST_CMD(CMD)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] script [32];
  int idx = 0, nreads = 0, nwrites = 0, lat = 0, wc = 0, addr_err = 0;
  logic [AW-1:0] wr_addr_seen;
  logic [DW-1:0] wr_data_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash responder: replays script bytes, acknowledges writes
  initial begin
    rd_ack_i = 1'b0; rd_data_i = '0; wr_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (wc >= lat) begin
          rd_ack_i  = 1'b1;
          rd_data_i = script[idx];
          if (idx < 31) idx++;
          nreads++;
          wc = 0;
        end else begin
          rd_ack_i = 1'b0;
          wc++;
        end
      end else begin
        rd_ack_i = 1'b0;
        wc = 0;
      end
      if (wr_req_o && !wr_ack_i) begin
        wr_ack_i = 1'b1;
        wr_addr_seen = wr_addr_o;
        wr_data_seen = wr_data_o;
        nwrites++;
      end else begin
        wr_ack_i = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic load(input logic [7:0] v [], input int l);
    for (int i = 0; i < 32; i++) script[i] = (i < v.size()) ? v[i] : v[v.size()-1];
    idx = 0; nreads = 0; nwrites = 0; lat = l; wc = 0; addr_err = 0;
    wr_addr_seen = '0; wr_data_seen = '0;
  endtask

  // start an operation, wait for done, check verdict and counts
  task automatic run_op(input string req, input logic [AW-1:0] a, input logic exp_pass,
                        input int exp_reads, input int exp_wr, input bit poke_busy);
    int n;
    @(negedge clk);
    start_i = 1'b1; addr_i = a;
    @(negedge clk);
    start_i = 1'b0; addr_i = '0;
    chk({req, " R2 rd_req after start"}, rd_req_o, 1'b1);
    chk({req, " R2 rd_addr"}, rd_addr_o, a);
    n = 0;
    while (!done_o && n < 200) begin
      if (poke_busy && n == 2) begin start_i = 1'b1; addr_i = ~a; end
      else begin start_i = 1'b0; end
      if (rd_req_o && rd_addr_o !== a) addr_err++;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk({req, " R9 done seen"}, done_o, 1'b1);
    chk({req, " R9 pass"}, pass_o, exp_pass);
    chk({req, " R10 read count"}, nreads, exp_reads);
    chk({req, " R2 addr steady"}, addr_err, 0);
    chk({req, " R8 write count"}, nwrites, exp_wr);
    if (exp_wr != 0) begin
      chk({req, " R8 write addr"}, wr_addr_seen, a);
      chk({req, " R8 write data"}, wr_data_seen, CMD);
    end
    @(negedge clk);
    chk({req, " R9 done one cycle"}, done_o, 1'b0);
    chk({req, " R9 pass held"}, pass_o, exp_pass);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 pass", pass_o, 1'b0);
    chk("R1 rd_req", rd_req_o, 1'b0);
    chk("R1 wr_req", wr_req_o, 1'b0);
  endtask

  task automatic t_quick_pass;   // R3 R4: first read only primes
    load('{8'h40, 8'h40}, 0);
    run_op("R4 quick", 16'h1234, 1'b1, 2, 0, 1'b0);
  endtask

  task automatic t_first_only;   // R3: differing first pair continues
    load('{8'h40, 8'h00, 8'h00}, 0);
    run_op("R3 prime", 16'h0101, 1'b1, 3, 0, 1'b0);
  endtask

  task automatic t_long_toggle;  // R5
    load('{8'h00, 8'h40, 8'h00, 8'h40, 8'h40}, 0);
    run_op("R5 toggling", 16'h2222, 1'b1, 5, 0, 1'b0);
  endtask

  task automatic t_err_late_pass; // R6 confirm read steady
    load('{8'h00, 8'h60, 8'h60}, 0);
    run_op("R6 confirm steady", 16'h3333, 1'b1, 3, 0, 1'b0);
  endtask

  task automatic t_err_fail;     // R6 R8 confirm read still toggling
    load('{8'h00, 8'h60, 8'h20}, 0);
    run_op("R6 confirm toggle", 16'h4444, 1'b0, 3, 1, 1'b0);
  endtask

  task automatic t_timeout;      // R7 R8
    load('{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
           8'h00, 8'h40, 8'h00, 8'h40}, 0);
    run_op("R7 limit", 16'h5555, 1'b0, MAXP, 1, 1'b0);
  endtask

  task automatic t_busy_start;   // R2 R10 with wait states and stray start
    load('{8'h00, 8'h40, 8'h40}, 3);
    run_op("R2 busy start", 16'h6666, 1'b1, 3, 0, 1'b1);
    chk("R2 stray start left idle", busy_o, 1'b0);
  endtask

  initial begin
    start_i = 1'b0; addr_i = '0; rst_n = 1'b0;
    for (int i = 0; i < 32; i++) script[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quick_pass();
    t_first_only();
    t_long_toggle();
    t_err_late_pass();
    t_err_fail();
    t_timeout();
    t_busy_start();
    t_quick_pass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule